// File: doc/BRIEF.md
# CPU Exception Entry Sequencer

This block steps a small 16-bit processor through three phases: fetching a new instruction word, running instructions, and entering an exception. It holds the saved exception context: the exception number, the return PC, the saved status word and one spare user word. Instructions can read and write that context. The block also handles the return from an exception.

When an exception is raised, the block records its number. On the following cycle it does four things:

- It reads the handler address from memory at the vector base plus the exception number.
- It saves the PC minus one instruction width as the return PC.
- It saves the status word.
- It writes the status word back with its two interrupt-enable bits cleared.

It then asks for a fresh fetch. The block also checks each memory access, and a 16-bit access to an odd address raises the unaligned exception.

The execute stage reports a software trap with its number, an undefined sub-opcode, a write to the PC, or a context operation. Context operations are encoded on a 4-bit field:

| Code | Operation |
|---|---|
| 0 | none |
| 1 | return from exception |
| 2 | read saved PC |
| 3 | write saved PC |
| 4 | read saved status |
| 5 | write saved status |
| 6 | read saved user word |
| 7 | write saved user word |
| 8 | read exception number |
| 9 | write exception number |
| 10 to 15 | no effect |

Top module: `exc_seq_top`

## Requirements
- R1: After reset the phase output is 0 (need-fetch), `fetch_req` is high, and all four saved context words read back as 0.
- R2: Phase 0 lasts one cycle: `fetch_req` is high in it, and the phase is 1 (run) on the next cycle.
- R3: In phase 1 with `run_valid` high, a 16-bit access (`mem_wide`=1) to an odd address drives `mem_force_ones` high in the same cycle and records exception number 2. A byte access to an odd address or a 16-bit access to an even address raises nothing.
- R4: Phase 2 (exception entry) lasts one cycle and is followed by phase 0. In phase 2:
  - `vec_rd` is high and `vec_addr` = `vec_base` + exception number.
  - `pc_we` is high with `pc_wdata` = `vec_data`.
  - `sr_we` is high with `sr_wdata` = `sr_cur` with bits 0 and 1 cleared.
- R5: Exception entry stores `pc_cur` − 2 as the saved PC and `sr_cur` as the saved status.
- R6: In phase 1 with `run_valid` high:
  - `trap_req` records `trap_num` as the exception number.
  - Otherwise `bad_op` records number 3.
  - Either one moves the phase to 2 on the next cycle.
- R7: A return from exception (op code 1) drives three writes in the same cycle:
  - `pc_we` with the saved PC.
  - `sr_we` with the saved status.
  - `reg_we` with the saved user word.
  
  The phase is 0 on the next cycle.
- R8: `pc_written` in phase 1 with `run_valid` high moves the phase to 0 on the next cycle.
- R9: Read ops (codes 2, 4, 6, 8) drive `reg_we` high with `reg_wdata` equal to the selected saved word in the same cycle. Write ops (codes 3, 5, 7, 9) load `ctx_wdata` into the selected word at the clock edge.
- R10: A misaligned 16-bit access beats everything else in its cycle. Any trap, return, context op or PC write in that cycle is dropped: no `pc_we`, `sr_we` or `reg_we`, and no context change. The next phase is 2.
- R11: In phase 1 with `run_valid` low, the inputs have no effect: no writes, no context change, and the phase stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vec_base | input | 16 | Base address of the vector table |
| pc_cur | input | 16 | Current program counter |
| sr_cur | input | 16 | Current status word |
| run_valid | input | 1 | An instruction completes this cycle |
| ctx_op | input | 4 | Context operation code |
| ctx_wdata | input | 16 | Data for context write ops |
| trap_req | input | 1 | Software trap requested |
| trap_num | input | 16 | Exception number of the trap |
| bad_op | input | 1 | Undefined sub-opcode decoded |
| pc_written | input | 1 | Instruction wrote the PC |
| mem_valid | input | 1 | Memory access this cycle |
| mem_wide | input | 1 | Access is 16-bit |
| mem_addr | input | 16 | Access address |
| vec_data | input | 16 | Word read from the vector table |
| state_o | output | 2 | Phase: 0 need-fetch, 1 run, 2 entry |
| fetch_req | output | 1 | Fetch an instruction word |
| vec_rd | output | 1 | Vector table read |
| vec_addr | output | 16 | Vector table address |
| pc_we | output | 1 | PC write enable |
| pc_wdata | output | 16 | PC write value |
| sr_we | output | 1 | Status write enable |
| sr_wdata | output | 16 | Status write value |
| reg_we | output | 1 | Destination register write enable |
| reg_wdata | output | 16 | Destination register write value |
| mem_force_ones | output | 1 | Replace read data with all ones |

## Verification
Two events can land in the same run cycle: a misaligned 16-bit access from the memory stage, and the completion of an instruction. The completion may be a return, a trap or a PC write. The bench drives a return, a trap and a PC write together with an odd-address 16-bit access in one cycle. It then expects three results:
- no PC, status or register write in that cycle;
- an entry cycle that vectors through offset 2;
- a saved exception number of 2 when it is read back.

// File: rtl/exc_seq_pkg.sv
`timescale 1ns/1ps
package exc_seq_pkg;
  localparam int unsigned WORD_W = 16;
  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    ST_FETCH = 2'd0,
    ST_RUN   = 2'd1,
    ST_ENTRY = 2'd2
  } seq_state_e;

  typedef enum logic [3:0] {
    OP_NONE    = 4'd0,
    OP_RETURN  = 4'd1,
    OP_GET_PC  = 4'd2,
    OP_SET_PC  = 4'd3,
    OP_GET_SR  = 4'd4,
    OP_SET_SR  = 4'd5,
    OP_GET_USR = 4'd6,
    OP_SET_USR = 4'd7,
    OP_GET_NUM = 4'd8,
    OP_SET_NUM = 4'd9
  } ctx_op_e;

  localparam word_t NUM_UNALIGNED = word_t'(2);
  localparam word_t NUM_BAD_OP    = word_t'(3);

  function automatic word_t vector_addr(word_t base, word_t num);
    return base + num;
  endfunction

  function automatic word_t return_pc(word_t pc, int unsigned rewind);
    return pc - word_t'(rewind);
  endfunction

  function automatic word_t strip_enables(word_t sr, int unsigned nbits);
    word_t mask;
    mask = word_t'((1 << nbits) - 1);
    return sr & ~mask;
  endfunction

  function automatic logic is_misaligned(logic wide, word_t addr);
    return wide & addr[0];
  endfunction
endpackage

// File: rtl/exc_align_chk.sv
`timescale 1ns/1ps
module exc_align_chk
  import exc_seq_pkg::*;
(
  input  logic  mem_valid,
  input  logic  mem_wide,
  input  word_t mem_addr,
  output logic  misalign
);
  assign misalign = mem_valid & is_misaligned(mem_wide, mem_addr);
endmodule

// File: rtl/exc_seq_fsm.sv
`timescale 1ns/1ps
module exc_seq_fsm
  import exc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_valid,
  input  logic       misalign,
  input  logic       trap_req,
  input  logic       bad_op,
  input  logic       ret_op,
  input  logic       pc_written,
  output seq_state_e state,
  output logic       take_mem,
  output logic       take_trap,
  output logic       take_bad,
  output logic       raise_ev,
  output logic       commit_ev,
  output logic       enter_ev
);
  seq_state_e state_nx;
  logic       active;

  assign active    = (state == ST_RUN) && run_valid;
  assign take_mem  = active && misalign;
  assign take_trap = active && !misalign && trap_req;
  assign take_bad  = active && !misalign && !trap_req && bad_op;
  assign raise_ev  = take_mem | take_trap | take_bad;
  assign commit_ev = active && !raise_ev;
  assign enter_ev  = (state == ST_ENTRY);

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_FETCH: state_nx = ST_RUN;
      ST_RUN: begin
        if (raise_ev)                              state_nx = ST_ENTRY;
        else if (commit_ev && (ret_op || pc_written)) state_nx = ST_FETCH;
      end
      ST_ENTRY: state_nx = ST_FETCH;
      default:  state_nx = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_FETCH;
    else        state <= state_nx;
  end

  assert_fetch_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FETCH) |=> (state == ST_RUN));
  assert_entry_to_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ENTRY) |=> (state == ST_FETCH));
  assert_raise_enters_R6: assert property (@(posedge clk) disable iff (!rst_n)
    raise_ev |=> (state == ST_ENTRY));
  assert_refetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_ev && pc_written) |=> (state == ST_FETCH));
  assert_idle_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && !run_valid) |=> (state == ST_RUN));
  assert_mem_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    take_mem |-> (!commit_ev && !take_trap && !take_bad));
endmodule

// File: rtl/exc_ctx_regs.sv
`timescale 1ns/1ps
module exc_ctx_regs
  import exc_seq_pkg::*;
#(
  parameter int unsigned PC_REWIND = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    commit_ev,
  input  logic    enter_ev,
  input  logic    take_mem,
  input  logic    take_trap,
  input  logic    take_bad,
  input  ctx_op_e op,
  input  word_t   wdata,
  input  word_t   trap_num,
  input  word_t   pc_cur,
  input  word_t   sr_cur,
  output word_t   saved_pc,
  output word_t   saved_sr,
  output word_t   saved_usr,
  output word_t   saved_num,
  output word_t   rdata,
  output logic    get_ev
);
  always_comb begin
    rdata  = '0;
    get_ev = 1'b0;
    case (op)
      OP_GET_PC:  begin rdata = saved_pc;  get_ev = 1'b1; end
      OP_GET_SR:  begin rdata = saved_sr;  get_ev = 1'b1; end
      OP_GET_USR: begin rdata = saved_usr; get_ev = 1'b1; end
      OP_GET_NUM: begin rdata = saved_num; get_ev = 1'b1; end
      OP_RETURN:  rdata = saved_usr;
      default:    rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      saved_pc  <= '0;
      saved_sr  <= '0;
      saved_usr <= '0;
      saved_num <= '0;
    end else begin
      if (take_mem)       saved_num <= NUM_UNALIGNED;
      else if (take_trap) saved_num <= trap_num;
      else if (take_bad)  saved_num <= NUM_BAD_OP;
      if (enter_ev) begin
        saved_pc <= return_pc(pc_cur, PC_REWIND);
        saved_sr <= sr_cur;
      end
      if (commit_ev) begin
        case (op)
          OP_SET_PC:  saved_pc  <= wdata;
          OP_SET_SR:  saved_sr  <= wdata;
          OP_SET_USR: saved_usr <= wdata;
          OP_SET_NUM: saved_num <= wdata;
          default: ;
        endcase
      end
    end
  end

  assert_entry_saves_R5: assert property (@(posedge clk) disable iff (!rst_n)
    enter_ev |=> (saved_pc == return_pc($past(pc_cur), PC_REWIND)) && (saved_sr == $past(sr_cur)));
  assert_unaligned_num_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take_mem |=> (saved_num == NUM_UNALIGNED));
  assert_set_num_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_ev && op == OP_SET_NUM) |=> (saved_num == $past(wdata)));
  assert_ctx_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit_ev && !enter_ev && !take_mem && !take_trap && !take_bad) |=>
      ($stable(saved_pc) && $stable(saved_sr) && $stable(saved_usr) && $stable(saved_num)));
endmodule

// File: rtl/exc_seq_top.sv
`timescale 1ns/1ps
module exc_seq_top
  import exc_seq_pkg::*;
#(
  parameter int unsigned PC_REWIND = 2,
  parameter int unsigned IE_BITS   = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] vec_base,
  input  logic [15:0] pc_cur,
  input  logic [15:0] sr_cur,
  input  logic        run_valid,
  input  logic [3:0]  ctx_op,
  input  logic [15:0] ctx_wdata,
  input  logic        trap_req,
  input  logic [15:0] trap_num,
  input  logic        bad_op,
  input  logic        pc_written,
  input  logic        mem_valid,
  input  logic        mem_wide,
  input  logic [15:0] mem_addr,
  input  logic [15:0] vec_data,
  output logic [1:0]  state_o,
  output logic        fetch_req,
  output logic        vec_rd,
  output logic [15:0] vec_addr,
  output logic        pc_we,
  output logic [15:0] pc_wdata,
  output logic        sr_we,
  output logic [15:0] sr_wdata,
  output logic        reg_we,
  output logic [15:0] reg_wdata,
  output logic        mem_force_ones
);
  seq_state_e state;
  ctx_op_e    op;
  logic       misalign, take_mem, take_trap, take_bad, raise_ev, commit_ev, enter_ev;
  logic       ret_op, ret_ev, get_ev;
  word_t      saved_pc, saved_sr, saved_usr, saved_num, ctx_rdata;

  assign op     = ctx_op_e'(ctx_op);
  assign ret_op = (op == OP_RETURN);
  assign ret_ev = commit_ev && ret_op;

  exc_align_chk align_i (
    .mem_valid (mem_valid),
    .mem_wide  (mem_wide),
    .mem_addr  (mem_addr),
    .misalign  (misalign)
  );

  exc_seq_fsm fsm_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_valid  (run_valid),
    .misalign   (misalign),
    .trap_req   (trap_req),
    .bad_op     (bad_op),
    .ret_op     (ret_op),
    .pc_written (pc_written),
    .state      (state),
    .take_mem   (take_mem),
    .take_trap  (take_trap),
    .take_bad   (take_bad),
    .raise_ev   (raise_ev),
    .commit_ev  (commit_ev),
    .enter_ev   (enter_ev)
  );

  exc_ctx_regs #(.PC_REWIND(PC_REWIND)) ctx_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit_ev (commit_ev),
    .enter_ev  (enter_ev),
    .take_mem  (take_mem),
    .take_trap (take_trap),
    .take_bad  (take_bad),
    .op        (op),
    .wdata     (ctx_wdata),
    .trap_num  (trap_num),
    .pc_cur    (pc_cur),
    .sr_cur    (sr_cur),
    .saved_pc  (saved_pc),
    .saved_sr  (saved_sr),
    .saved_usr (saved_usr),
    .saved_num (saved_num),
    .rdata     (ctx_rdata),
    .get_ev    (get_ev)
  );

  assign state_o        = state;
  assign fetch_req      = (state == ST_FETCH);
  assign vec_rd         = enter_ev;
  assign vec_addr       = vector_addr(vec_base, saved_num);
  assign pc_we          = enter_ev | ret_ev;
  assign pc_wdata       = enter_ev ? vec_data : saved_pc;
  assign sr_we          = enter_ev | ret_ev;
  assign sr_wdata       = enter_ev ? strip_enables(sr_cur, IE_BITS) : saved_sr;
  assign reg_we         = ret_ev | (commit_ev && get_ev);
  assign reg_wdata      = ctx_rdata;
  assign mem_force_ones = misalign;

  assert_mem_blocks_writes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (misalign && state == ST_RUN && run_valid) |-> (!pc_we && !sr_we && !reg_we));
  assert_vector_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vec_rd |-> (pc_we && sr_we && !reg_we));
  assert_return_refetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ret_ev |=> (state == ST_FETCH));
  assert_fetch_alone_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> (!vec_rd && !pc_we && !reg_we));
endmodule

// File: tb/exc_seq_tb.sv
`timescale 1ns/1ps
module exc_seq_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] vec_base = 16'h0200, pc_cur = '0, sr_cur = '0, ctx_wdata = '0;
  logic [15:0] trap_num = '0, mem_addr = '0, vec_data = 16'h0400;
  logic        run_valid = 1'b0, trap_req = 1'b0, bad_op = 1'b0, pc_written = 1'b0;
  logic        mem_valid = 1'b0, mem_wide = 1'b0;
  logic [3:0]  ctx_op = '0;
  logic [1:0]  state_o;
  logic        fetch_req, vec_rd, pc_we, sr_we, reg_we, mem_force_ones;
  logic [15:0] vec_addr, pc_wdata, sr_wdata, reg_wdata;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  exc_seq_top dut_i (
    .clk(clk), .rst_n(rst_n), .vec_base(vec_base), .pc_cur(pc_cur), .sr_cur(sr_cur),
    .run_valid(run_valid), .ctx_op(ctx_op), .ctx_wdata(ctx_wdata), .trap_req(trap_req),
    .trap_num(trap_num), .bad_op(bad_op), .pc_written(pc_written), .mem_valid(mem_valid),
    .mem_wide(mem_wide), .mem_addr(mem_addr), .vec_data(vec_data), .state_o(state_o),
    .fetch_req(fetch_req), .vec_rd(vec_rd), .vec_addr(vec_addr), .pc_we(pc_we),
    .pc_wdata(pc_wdata), .sr_we(sr_we), .sr_wdata(sr_wdata), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .mem_force_ones(mem_force_ones)
  );

  typedef struct {
    string       req;
    logic [1:0]  st;
    logic        vr;
    logic [15:0] va;
    logic        pw;
    logic [15:0] pd;
    logic        sw;
    logic [15:0] sd;
    logic        rw;
    logic [15:0] rd;
    logic        fo;
  } exp_t;
  exp_t sb[$];

  function automatic void cmp(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endfunction

  // monitor: pops one expected item per cycle, late in the cycle
  initial begin
    forever begin
      @(posedge clk);
      #15;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        cmp(e.req, "state", 16'(state_o), 16'(e.st));
        cmp(e.req, "fetch_req", 16'(fetch_req), 16'(e.st == 2'd0));
        cmp(e.req, "vec_rd", 16'(vec_rd), 16'(e.vr));
        if (e.vr) cmp(e.req, "vec_addr", vec_addr, e.va);
        cmp(e.req, "pc_we", 16'(pc_we), 16'(e.pw));
        if (e.pw) cmp(e.req, "pc_wdata", pc_wdata, e.pd);
        cmp(e.req, "sr_we", 16'(sr_we), 16'(e.sw));
        if (e.sw) cmp(e.req, "sr_wdata", sr_wdata, e.sd);
        cmp(e.req, "reg_we", 16'(reg_we), 16'(e.rw));
        if (e.rw) cmp(e.req, "reg_wdata", reg_wdata, e.rd);
        cmp(e.req, "mem_force_ones", 16'(mem_force_ones), 16'(e.fo));
      end
    end
  end

  // driver: push expectation for the current cycle, then advance
  task automatic push(string req, logic [1:0] st, logic vr, logic [15:0] va,
                      logic pw, logic [15:0] pd, logic sw, logic [15:0] sd,
                      logic rw, logic [15:0] rd, logic fo);
    exp_t e;
    e.req = req; e.st = st; e.vr = vr; e.va = va; e.pw = pw; e.pd = pd;
    e.sw = sw; e.sd = sd; e.rw = rw; e.rd = rd; e.fo = fo;
    sb.push_back(e);
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    run_valid = 1'b1; ctx_op = 4'd0; ctx_wdata = '0; trap_req = 1'b0; trap_num = '0;
    bad_op = 1'b0; pc_written = 1'b0; mem_valid = 1'b0; mem_wide = 1'b0; mem_addr = '0;
  endtask

  task automatic quiet(string req, logic [1:0] st);
    push(req, st, 0, '0, 0, '0, 0, '0, 0, '0, 0);
  endtask

  task automatic get(string req, logic [3:0] code, logic [15:0] exp);
    idle(); ctx_op = code;
    push(req, 2'd1, 0, '0, 0, '0, 0, '0, 1, exp, 0);
  endtask

  task automatic set(string req, logic [3:0] code, logic [15:0] val);
    idle(); ctx_op = code; ctx_wdata = val;
    quiet(req, 2'd1);
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle();
    run_valid = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    rst_n = 1'b1;
    idle();
    quiet("R1 R2 need-fetch after reset", 2'd0);
    get("R1 saved PC zero", 4'd2, 16'h0000);
    get("R1 saved status zero", 4'd4, 16'h0000);
    get("R1 saved user zero", 4'd6, 16'h0000);
    get("R1 exception number zero", 4'd8, 16'h0000);

    set("R9 write user word", 4'd7, 16'h1234);
    get("R9 user word readback", 4'd6, 16'h1234);

    // R11: stalled cycle ignores a context write and a trap
    idle(); run_valid = 1'b0; ctx_op = 4'd3; ctx_wdata = 16'hBEEF; trap_req = 1'b1;
    quiet("R11 stalled cycle no effect", 2'd1);
    get("R11 saved PC untouched", 4'd2, 16'h0000);

    // R3: byte access at odd address, wide access at even address
    idle(); mem_valid = 1'b1; mem_wide = 1'b0; mem_addr = 16'h0005;
    quiet("R3 odd byte access no exception", 2'd1);
    idle(); mem_valid = 1'b1; mem_wide = 1'b1; mem_addr = 16'h0004;
    quiet("R3 even wide access no exception", 2'd1);
    get("R3 number unchanged", 4'd8, 16'h0000);

    // R8: PC write forces a refetch
    idle(); pc_written = 1'b1;
    quiet("R8 pc write cycle", 2'd1);
    idle();
    quiet("R8 refetch", 2'd0);

    // R6 R4 R5: trap with number 6
    idle(); trap_req = 1'b1; trap_num = 16'h0006;
    quiet("R6 trap raise", 2'd1);
    idle(); pc_cur = 16'h0100; sr_cur = 16'h001F; vec_data = 16'h0400;
    push("R4 trap vector entry", 2'd2, 1, 16'h0206, 1, 16'h0400, 1, 16'h001C, 0, '0, 0);
    idle();
    quiet("R4 fetch after entry", 2'd0);
    get("R5 saved PC", 4'd2, 16'h00FE);
    get("R5 saved status", 4'd4, 16'h001F);
    get("R6 trap number", 4'd8, 16'h0006);

    // R6: undefined sub-opcode gives number 3
    idle(); bad_op = 1'b1;
    quiet("R6 bad opcode raise", 2'd1);
    idle(); pc_cur = 16'h0300; sr_cur = 16'h0003; vec_data = 16'h0500;
    push("R6 R4 bad opcode vector", 2'd2, 1, 16'h0203, 1, 16'h0500, 1, 16'h0000, 0, '0, 0);
    idle();
    quiet("R4 fetch after entry 2", 2'd0);
    get("R6 number is 3", 4'd8, 16'h0003);

    // R7: return from exception
    idle(); ctx_op = 4'd1;
    push("R7 return restores", 2'd1, 0, '0, 1, 16'h02FE, 1, 16'h0003, 1, 16'h1234, 0);
    idle();
    quiet("R7 refetch after return", 2'd0);

    // R10: misaligned wide access collides with return, trap and pc write
    idle(); mem_valid = 1'b1; mem_wide = 1'b1; mem_addr = 16'h0011;
    ctx_op = 4'd1; trap_req = 1'b1; trap_num = 16'h0009; pc_written = 1'b1;
    push("R10 R3 collision drops completion", 2'd1, 0, '0, 0, '0, 0, '0, 0, '0, 1);
    idle(); pc_cur = 16'h0410; sr_cur = 16'h0000; vec_data = 16'h0600;
    push("R10 R3 unaligned vector", 2'd2, 1, 16'h0202, 1, 16'h0600, 1, 16'h0000, 0, '0, 0);
    idle();
    quiet("R10 fetch after entry", 2'd0);
    get("R3 number is 2", 4'd8, 16'h0002);
    get("R5 saved PC after unaligned", 4'd2, 16'h040E);

    // R10: a context write in a colliding cycle is dropped
    idle(); mem_valid = 1'b1; mem_wide = 1'b1; mem_addr = 16'h0001;
    ctx_op = 4'd7; ctx_wdata = 16'hAAAA;
    push("R10 set dropped", 2'd1, 0, '0, 0, '0, 0, '0, 0, '0, 1);
    idle(); vec_data = 16'h0700;
    push("R10 entry", 2'd2, 1, 16'h0202, 1, 16'h0700, 1, 16'h0000, 0, '0, 0);
    idle();
    quiet("R10 fetch", 2'd0);
    get("R10 user word kept", 4'd6, 16'h1234);

    set("R9 write number", 4'd9, 16'h0001);
    get("R9 number readback", 4'd8, 16'h0001);
    set("R9 write status", 4'd5, 16'h00F0);
    get("R9 status readback", 4'd4, 16'h00F0);

    @(posedge clk);
    #16;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule